// File: doc/BRIEF.md
# Nested Loop Schedule Token Sequencer

This block steps one shared execution resource through a fixed nested looped schedule: an outer loop that repeats the group (A, then B an inner number of times, then C). Control is held by a single one-hot token that acts as an actor-level program counter. The token passes through two loop control nodes and three actor reference nodes, and whichever node holds it is the one that acts next.

When the token reaches an actor node, that node makes a guarded firing. If the actor's enable input is high, the node issues a one-cycle fire strobe and holds the token until the actor returns a done pulse. If the enable is low, the visit is skipped, the token moves on in the next cycle and a skip counter increments.

A start pulse loads the outer repeat count and launches the schedule. When the outer count runs out, the block drops busy and raises a finished flag. A forever mode replaces the trip back through the outer loop node with a direct return from C to A, so the schedule runs until reset.

Top module: `sched_token_seq`

## Requirements
- R1: After reset, busy, finished, every fire strobe and the skip count are all 0.
- R2: A start pulse while idle loads the outer count J from `outer_count`. The firing order is then (A, B repeated INNER_COUNT times, C) repeated J times, followed by busy falling and finished rising. Fire bit 0 is A, bit 1 is B and bit 2 is C.
- R3: With J = 0 the sequencer finishes without firing any actor.
- R4: Each arrival from A reloads the inner count, so every outer iteration contains exactly INNER_COUNT visits to B, whatever came before.
- R5: An actor whose enable bit is low when the token reaches it is not fired. The token passes on in the next cycle and `skip_count` rises by one for each skipped visit.
- R6: A fire strobe is high for one cycle only. No other actor is fired until the fired actor's done bit returns.
- R7: With `run_forever` high, C hands the token straight back to A. The schedule repeats without end: busy stays high and finished stays low.
- R8: finished stays high until the next accepted start. A start pulse while busy is ignored and does not change the schedule in progress.
- R9: At most one fire bit is high in any cycle, and no fire bit is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle launch request, accepted only while idle |
| outer_count | input | CNT_W | Outer repeat count J, sampled at start |
| run_forever | input | 1 | Repeat the schedule indefinitely |
| act_en | input | 3 | Per-actor enable (bit 0 = A, 1 = B, 2 = C) |
| act_done | input | 3 | Per-actor completion pulse |
| act_fire | output | 3 | Per-actor one-cycle fire strobe |
| busy | output | 1 | Schedule in progress |
| finished | output | 1 | Schedule completed, held until next start |
| skip_count | output | SKIP_W | Number of skipped guarded firings since reset |

## Verification
The schedule is run with all actors enabled for J = 3, 1 and 0. These separate the nesting order, a single pass and the immediate-end case. Runs with B disabled and with A and C disabled show that the skip path advances the token, that the counter tracks each skip, and that the inner loop still counts its B visits when none of them fire. A long done latency, combined with a start pulse issued mid-run, separates holding the token for the handshake from ignoring a busy start. A forever-mode run that is stopped by reset shows the direct return from C to A.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam int TOK_N   = 7;
  localparam int P_OUTER = 0;
  localparam int P_A     = 1;
  localparam int P_IENT  = 2;
  localparam int P_B     = 3;
  localparam int P_IRET  = 4;
  localparam int P_C     = 5;
  localparam int P_END   = 6;
  localparam int NACT    = 3;

  function automatic logic [TOK_N-1:0] tok_at(input int p);
    logic [TOK_N-1:0] v;
    v = '0;
    v[p] = 1'b1;
    return v;
  endfunction

  function automatic int actor_pos(input int i);
    return (i == 0) ? P_A : (i == 1) ? P_B : P_C;
  endfunction
endpackage

// File: rtl/sts_actor_ref.sv
module sts_actor_ref (
  input  logic clk,
  input  logic rst_n,
  input  logic tok_here,
  input  logic en,
  input  logic done,
  output logic fire,
  output logic pass,
  output logic skipped
);
  logic waiting;

  always_comb begin
    fire    = tok_here & ~waiting & en;
    skipped = tok_here & ~waiting & ~en;
    pass    = skipped | (waiting & done);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                waiting <= 1'b0;
    else if (fire)             waiting <= 1'b1;
    else if (waiting && done)  waiting <= 1'b0;
  end

  // R6: while waiting for done the token must stay at this node
  p_wait_holds_token_r6: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> tok_here);
  // R6: fire strobe lasts one cycle
  p_fire_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/sts_inner_loop.sv
module sts_inner_loop #(
  parameter int INNER_COUNT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tok_ent,
  input  logic tok_ret,
  output logic to_b,
  output logic to_c
);
  localparam int IW = $clog2(INNER_COUNT + 1);

  logic [IW-1:0] cnt;
  logic          more;

  function automatic logic left_after_dec(input logic [IW-1:0] c);
    return c > IW'(1);
  endfunction

  always_comb begin
    more = left_after_dec(cnt);
    to_b = tok_ent | (tok_ret & more);
    to_c = tok_ret & ~more;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (tok_ent) cnt <= IW'(INNER_COUNT);
    else if (tok_ret) cnt <= cnt - IW'(1);
  end

  // R4: count never exceeds the configured inner count
  p_inner_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= IW'(INNER_COUNT));
  // R4: a return from B only happens after an entry loaded the count
  p_ret_after_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tok_ret |-> cnt != '0);
endmodule

// File: rtl/sts_outer_loop.sv
module sts_outer_loop #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tok_here,
  input  logic             forever_mode,
  output logic             to_a,
  output logic             to_end
);
  logic [CNT_W-1:0] cnt;

  function automatic logic exhausted(input logic [CNT_W-1:0] c);
    return c == '0;
  endfunction

  always_comb begin
    to_end = tok_here & ~forever_mode & exhausted(cnt);
    to_a   = tok_here & ~to_end;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                cnt <= '0;
    else if (load)                             cnt <= load_val;
    else if (tok_here && !forever_mode && !exhausted(cnt)) cnt <= cnt - CNT_W'(1);
  end

  // R3: end is reached once; the token leaves the loop node afterwards
  p_end_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    to_end |=> !tok_here);
  // R7: in forever mode the outer node never ends the schedule
  p_forever_no_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    forever_mode |-> !to_end);
endmodule

// File: rtl/sched_token_seq.sv
module sched_token_seq #(
  parameter int CNT_W       = 8,
  parameter int SKIP_W      = 16,
  parameter int INNER_COUNT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  outer_count,
  input  logic              run_forever,
  input  logic [2:0]        act_en,
  input  logic [2:0]        act_done,
  output logic [2:0]        act_fire,
  output logic              busy,
  output logic              finished,
  output logic [SKIP_W-1:0] skip_count
);
  import sts_pkg::*;

  logic [TOK_N-1:0] tok, tok_nxt;
  logic [NACT-1:0]  pass, skipped;
  logic             start_ok;
  logic             out_to_a, out_to_end, in_to_b, in_to_c;

  assign start_ok = start & ~busy;

  sts_outer_loop #(.CNT_W(CNT_W)) u_outer (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .load_val(outer_count),
    .tok_here(tok[P_OUTER] & busy), .forever_mode(run_forever),
    .to_a(out_to_a), .to_end(out_to_end));

  sts_inner_loop #(.INNER_COUNT(INNER_COUNT)) u_inner (
    .clk(clk), .rst_n(rst_n), .tok_ent(tok[P_IENT]), .tok_ret(tok[P_IRET]),
    .to_b(in_to_b), .to_c(in_to_c));

  for (genvar i = 0; i < NACT; i++) begin : g_act
    sts_actor_ref u_ref (
      .clk(clk), .rst_n(rst_n), .tok_here(tok[actor_pos(i)]),
      .en(act_en[i]), .done(act_done[i]), .fire(act_fire[i]),
      .pass(pass[i]), .skipped(skipped[i]));
  end

  always_comb begin
    tok_nxt = tok;
    if (out_to_a)   tok_nxt = tok_at(P_A);
    if (out_to_end) tok_nxt = tok_at(P_END);
    if (pass[0])    tok_nxt = tok_at(P_IENT);
    if (in_to_b)    tok_nxt = tok_at(P_B);
    if (pass[1])    tok_nxt = tok_at(P_IRET);
    if (in_to_c)    tok_nxt = tok_at(P_C);
    if (pass[2])    tok_nxt = run_forever ? tok_at(P_A) : tok_at(P_OUTER);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok        <= tok_at(P_OUTER);
      busy       <= 1'b0;
      finished   <= 1'b0;
      skip_count <= '0;
    end else begin
      if (start_ok) begin
        tok      <= tok_at(P_OUTER);
        busy     <= 1'b1;
        finished <= 1'b0;
      end else begin
        tok <= tok_nxt;
        if (out_to_end) begin
          busy     <= 1'b0;
          finished <= 1'b1;
        end
      end
      if (|skipped) skip_count <= skip_count + SKIP_W'(1);
    end
  end

  // R9: exactly one token in the sequencer
  p_one_token_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(tok));
  // R9: at most one actor fired at a time
  p_single_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_fire));
  // R9: idle sequencer fires nothing
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> act_fire == '0);
  // R8: finished and busy are exclusive
  p_finish_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> !busy);
endmodule

// File: tb/sched_token_seq_tb.sv
module sched_token_seq_tb;
  localparam int CNT_W = 8;
  localparam int SKIP_W = 16;
  localparam int INNER = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] outer_count = '0;
  logic run_forever = 1'b0;
  logic [2:0] act_en = 3'b111;
  logic [2:0] act_done = 3'b000;
  logic [2:0] act_fire;
  logic busy, finished;
  logic [SKIP_W-1:0] skip_count;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int lat = 1;
  int exp_skip = 0;
  int pend[3] = '{0, 0, 0};
  int expq[$];

  always #5 clk = ~clk;

  sched_token_seq #(.CNT_W(CNT_W), .SKIP_W(SKIP_W), .INNER_COUNT(INNER)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .outer_count(outer_count),
    .run_forever(run_forever), .act_en(act_en), .act_done(act_done),
    .act_fire(act_fire), .busy(busy), .finished(finished), .skip_count(skip_count));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor + actor responder (scoreboard consumer)
  always @(negedge clk) begin
    act_done = 3'b000;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) pend[i] = 0;
    end else begin
      for (int i = 0; i < 3; i++)
        if (pend[i] > 0) begin
          pend[i]--;
          if (pend[i] == 0) act_done[i] = 1'b1;
        end
      for (int i = 0; i < 3; i++)
        if (act_fire[i]) begin
          int busy_pend;
          int exp;
          busy_pend = pend[0] + pend[1] + pend[2];
          check(busy_pend == 0, "R6 fire while handshake open", busy_pend, 0);
          if (expq.size() == 0) begin
            check(1'b0, "R2 unexpected firing", i, -1);
          end else begin
            exp = expq.pop_front();
            check(exp == i, "R2 firing order", i, exp);
          end
          pend[i] = lat;
        end
    end
  end

  // driver: pushes the expected firing sequence
  task automatic push_sched(input int j, input logic [2:0] en);
    for (int o = 0; o < j; o++) begin
      if (en[0]) expq.push_back(0); else exp_skip++;
      for (int k = 0; k < INNER; k++)
        if (en[1]) expq.push_back(1); else exp_skip++;
      if (en[2]) expq.push_back(2); else exp_skip++;
    end
  endtask

  task automatic pulse_start(input int j);
    @(negedge clk);
    outer_count = CNT_W'(j);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_finish(input string req);
    int t;
    t = 0;
    while (!finished && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(finished == 1'b1, req, finished, 1);
  endtask

  task automatic run(input int j, input logic [2:0] en, input string req);
    act_en = en;
    push_sched(j, en);
    pulse_start(j);
    wait_finish(req);
    @(negedge clk);
    check(busy == 1'b0, req, busy, 0);
    check(expq.size() == 0, req, expq.size(), 0);
    check(int'(skip_count) == exp_skip, req, int'(skip_count), exp_skip);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(finished == 1'b0, "R1 finished", finished, 0);
    check(act_fire == 3'b000, "R1 fire", act_fire, 0);
    check(skip_count == '0, "R1 skip", int'(skip_count), 0);

    // R2 / R4 full schedule, J=3
    run(3, 3'b111, "R2 J=3");
    // R8 finished held until next start
    repeat (10) @(negedge clk);
    check(finished == 1'b1, "R8 finished held", finished, 1);
    // R3 J=0
    run(0, 3'b111, "R3 J=0");
    // R2 single pass
    run(1, 3'b111, "R2 J=1");
    // R5 B disabled: skips still count inner visits (R4)
    run(2, 3'b101, "R5 B skipped");
    // R5 A and C disabled
    run(2, 3'b010, "R5 A C skipped");

    // R6 / R8 long latency and ignored busy start
    lat = 4;
    act_en = 3'b111;
    push_sched(2, 3'b111);
    pulse_start(2);
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R8 busy mid run", busy, 1);
    pulse_start(5);
    wait_finish("R8 busy start ignored");
    check(expq.size() == 0, "R8 busy start ignored", expq.size(), 0);
    lat = 1;

    // R7 forever mode
    run_forever = 1'b1;
    push_sched(4, 3'b111);
    pulse_start(1);
    begin
      int t;
      t = 0;
      while (expq.size() > 5 && t < 5000) begin
        @(negedge clk);
        t++;
      end
    end
    check(expq.size() <= 5, "R7 forever passes beyond J", expq.size(), 5);
    check(busy == 1'b1, "R7 busy", busy, 1);
    check(finished == 1'b0, "R7 not finished", finished, 0);
    rst_n = 1'b0;
    expq.delete();
    run_forever = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 reset after forever", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule